// File: doc/BRIEF.md
# ALU Status Flag Generator

This unit sits beside an ALU and turns one completed operation into the six arithmetic status flags: carry, parity, auxiliary carry, zero, sign and overflow. It receives the two operands, the result the ALU produced, a two-bit operation class and a width select for 8-bit or 16-bit work. On a write cycle it derives the flags at the selected width and captures them in a flag register. Every flag is derived from the operand and result bits alone, so the ALU does not have to export any internal carry chain.

Three control bits live in the same register: trap, interrupt enable and direction. They change only on explicit set or clear commands, and arithmetic writes never touch them. A direction value of 1 tells the string unit to decrement its index registers, and 0 tells it to increment them. Data move operations pass through the unit without disturbing any of the six arithmetic flags. This lets a load or store sit between a compare and the branch that tests it.

Top module: `alu_flag_gen`

## Requirements
- R1: While `rstN` is low, and on the first rising edge after it goes low, all nine outputs clear to 0.
- R2: Carry is the unsigned carry out of the selected width's top bit for class 0 (add) and the unsigned borrow (A < B) for class 1 (subtract). Width select `wide` = 1 means 16 bits, and 0 means the low 8 bits only.
- R3: Overflow for add is 1 when both operands share a sign and the result's sign differs from it. For subtract it is 1 when the operand signs differ and the result's sign differs from the minuend (A). Signs are taken at the selected width.
- R4: Auxiliary carry is the carry (add) or borrow (subtract) from bit 3 into bit 4.
- R5: Zero is 1 exactly when the result bits within the selected width are all 0. In 8-bit mode, result bits above bit 7 are ignored.
- R6: Sign equals result bit 7 in 8-bit mode and result bit 15 in 16-bit mode.
- R7: Parity is 1 when result bits 7..0 hold an even number of ones, and 0 when odd. This holds in 16-bit mode too.
- R8: For class 2 (logic), carry, overflow and auxiliary carry are written as 0, while zero, sign and parity follow R5 to R7.
- R9: For class 3 (move), or when `wrEn` is 0, all six arithmetic flags keep their values.
- R10: With `ctlWe` = 1, `ctlSel` picks a control bit (0 trap, 1 interrupt enable, 2 direction) and loads it with `ctlVal`. `ctlSel` = 3, `ctlWe` = 0 and arithmetic writes leave all three control bits unchanged.
- R11: Flags written on a rising edge appear on the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | DATA_W | First operand (minuend for subtract) |
| opB | input | DATA_W | Second operand (subtrahend for subtract) |
| res | input | DATA_W | ALU result for this operation |
| opClass | input | 2 | 0 add, 1 subtract, 2 logic, 3 move |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| wrEn | input | 1 | Capture the flags for this operation |
| ctlWe | input | 1 | Control bit command strobe |
| ctlSel | input | 2 | 0 trap, 1 interrupt enable, 2 direction, 3 none |
| ctlVal | input | 1 | Value written to the selected control bit |
| carryFlag | output | 1 | Carry / borrow |
| parityFlag | output | 1 | Even parity of result low byte |
| auxFlag | output | 1 | Nibble carry / borrow |
| zeroFlag | output | 1 | Result zero at selected width |
| signFlag | output | 1 | Result top bit at selected width |
| ovfFlag | output | 1 | Signed overflow |
| trapBit | output | 1 | Trap enable |
| intEnBit | output | 1 | Interrupt enable |
| dirBit | output | 1 | String direction (1 = decrement) |

## Verification
The bench builds the unit with its defaults: a 16-bit data width, an 8-bit byte and a 4-bit nibble. With these values both width lanes are live, and the same low-byte pattern can be sent through each lane to give different carry and zero results. The narrow vectors put unrelated values in the upper operand and result bits. That shows they are ignored, and that parity reads only the low byte even for 16-bit work. Overflow and borrow are covered in both directions across each sign boundary.

// File: rtl/flag_pkg.sv
package flag_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_MOVE  = 2'd3
  } opClass_t;

  localparam int CTL_N = 3;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } arithFlags_t;

  typedef struct packed {
    logic             loadArith;
    logic             logicOp;
    logic             subOp;
    logic             wideSel;
    logic [CTL_N-1:0] setBit;
    logic [CTL_N-1:0] clrBit;
  } flagStrobes_t;

endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic         [1:0] opClass,
  input  logic               wide,
  input  logic               wrEn,
  input  logic               ctlWe,
  input  logic         [1:0] ctlSel,
  input  logic               ctlVal,
  output flagStrobes_t       strb
);

  opClass_t cls;
  logic [CTL_N-1:0] setVec;
  logic [CTL_N-1:0] clrVec;

  assign cls = opClass_t'(opClass);

  // One command decoder per control bit; select code 3 matches none.
  for (genvar gi = 0; gi < CTL_N; gi++) begin : g_ctl
    logic hit;
    assign hit        = ctlWe && (ctlSel == 2'(gi));
    assign setVec[gi] = hit && ctlVal;
    assign clrVec[gi] = hit && !ctlVal;
  end

  always_comb begin
    strb           = '0;
    strb.loadArith = wrEn && (cls != OP_MOVE);
    strb.logicOp   = (cls == OP_LOGIC);
    strb.subOp     = (cls == OP_SUB);
    strb.wideSel   = wide;
    strb.setBit    = setVec;
    strb.clrBit    = clrVec;
  end

endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [DATA_W-1:0]   res,
  input  flagStrobes_t        strb,
  output arithFlags_t         flagQ,
  output logic [CTL_N-1:0]    ctlQ
);

  localparam int NUM_LANE = 2;

  logic [NUM_LANE-1:0] carryAt;
  logic [NUM_LANE-1:0] ovfAt;
  logic [NUM_LANE-1:0] signAt;
  logic [NUM_LANE-1:0] zeroAt;
  logic                nibCarry;
  logic                evenPar;
  arithFlags_t         flagD;
  logic                unusedOperand;

  // Lane 0 evaluates the narrow width, lane 1 the full width.
  for (genvar gi = 0; gi < NUM_LANE; gi++) begin : g_lane
    localparam int MSB = (gi == 0) ? BYTE_W - 1 : DATA_W - 1;
    logic aS, bS, rS, addOut, subOut;
    assign aS     = opA[MSB];
    assign bS     = opB[MSB];
    assign rS     = res[MSB];
    // Carry into the top bit equals aS^bS^rS; fold it into the carry-out.
    assign addOut = (aS & bS) | ((aS | bS) & ~rS);
    assign subOut = (~aS & bS) | ((~aS | bS) & rS);
    assign carryAt[gi] = strb.subOp ? subOut : addOut;
    assign ovfAt[gi]   = strb.subOp ? ((aS ^ bS) & (rS ^ aS))
                                    : (~(aS ^ bS) & (rS ^ aS));
    assign signAt[gi]  = rS;
    assign zeroAt[gi]  = ~|res[MSB:0];
  end

  assign nibCarry      = opA[NIB_W] ^ opB[NIB_W] ^ res[NIB_W];
  assign evenPar       = ~^res[BYTE_W-1:0];
  assign unusedOperand = ^{opA, opB};

  always_comb begin
    flagD.pf = evenPar;
    flagD.zf = zeroAt[strb.wideSel];
    flagD.sf = signAt[strb.wideSel];
    if (strb.logicOp) begin
      flagD.cf = 1'b0;
      flagD.af = 1'b0;
      flagD.of = 1'b0;
    end else begin
      flagD.cf = carryAt[strb.wideSel];
      flagD.af = nibCarry;
      flagD.of = ovfAt[strb.wideSel];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      ctlQ  <= '0;
    end else begin
      if (strb.loadArith) flagQ <= flagD;
      ctlQ <= (ctlQ | strb.setBit) & ~strb.clrBit;
    end
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] res,
  input  logic [1:0]        opClass,
  input  logic              wide,
  input  logic              wrEn,
  input  logic              ctlWe,
  input  logic [1:0]        ctlSel,
  input  logic              ctlVal,
  output logic              carryFlag,
  output logic              parityFlag,
  output logic              auxFlag,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              ovfFlag,
  output logic              trapBit,
  output logic              intEnBit,
  output logic              dirBit
);

  flagStrobes_t     strb;
  arithFlags_t      flagQ;
  logic [CTL_N-1:0] ctlQ;

  flag_ctrl u_ctrl (
    .opClass (opClass),
    .wide    (wide),
    .wrEn    (wrEn),
    .ctlWe   (ctlWe),
    .ctlSel  (ctlSel),
    .ctlVal  (ctlVal),
    .strb    (strb)
  );

  flag_datapath #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .NIB_W  (NIB_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .opA   (opA),
    .opB   (opB),
    .res   (res),
    .strb  (strb),
    .flagQ (flagQ),
    .ctlQ  (ctlQ)
  );

  assign carryFlag  = flagQ.cf;
  assign parityFlag = flagQ.pf;
  assign auxFlag    = flagQ.af;
  assign zeroFlag   = flagQ.zf;
  assign signFlag   = flagQ.sf;
  assign ovfFlag    = flagQ.of;
  assign trapBit    = ctlQ[0];
  assign intEnBit   = ctlQ[1];
  assign dirBit     = ctlQ[2];

endmodule

// File: rtl/alu_flag_gen_chk.sv
module alu_flag_gen_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] res,
  input logic [1:0]        opClass,
  input logic              wide,
  input logic              wrEn,
  input logic              ctlWe,
  input logic [1:0]        ctlSel,
  input logic              ctlVal,
  input logic              carryFlag,
  input logic              parityFlag,
  input logic              auxFlag,
  input logic              zeroFlag,
  input logic              signFlag,
  input logic              ovfFlag,
  input logic              trapBit,
  input logic              intEnBit,
  input logic              dirBit
);

  logic [5:0] arith;
  logic [2:0] ctl;
  logic [DATA_W-1:0] unusedHigh;
  assign arith = {carryFlag, parityFlag, auxFlag, zeroFlag, signFlag, ovfFlag};
  assign ctl   = {trapBit, intEnBit, dirBit};
  assign unusedHigh = res;

  a_r9_move_holds: assert property (@(posedge clk) disable iff (!rstN)
    (opClass == 2'd3) |=> $stable(arith));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(arith));

  a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opClass == 2'd2) |=> (!carryFlag && !ovfFlag && !auxFlag));

  a_r6_sign: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opClass != 2'd3) |=>
      (signFlag == ($past(wide) ? $past(res[DATA_W-1]) : $past(res[BYTE_W-1]))));

  a_r5_zero_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opClass != 2'd3 && !wide) |=> (zeroFlag == ($past(res[BYTE_W-1:0]) == '0)));

  a_r7_parity: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opClass != 2'd3) |=> (parityFlag == !($countones($past(res[BYTE_W-1:0])) % 2)));

  a_r10_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && ctlSel == 2'd2) |=> (dirBit == $past(ctlVal)));

  a_r10_ctl_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlWe || ctlSel == 2'd3) |=> $stable(ctl));

endmodule

bind alu_flag_gen alu_flag_gen_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .res(res), .opClass(opClass), .wide(wide),
  .wrEn(wrEn), .ctlWe(ctlWe), .ctlSel(ctlSel), .ctlVal(ctlVal),
  .carryFlag(carryFlag), .parityFlag(parityFlag), .auxFlag(auxFlag),
  .zeroFlag(zeroFlag), .signFlag(signFlag), .ovfFlag(ovfFlag),
  .trapBit(trapBit), .intEnBit(intEnBit), .dirBit(dirBit)
);

// File: tb/alu_flag_gen_tb.sv
`timescale 1ns/1ps
module alu_flag_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0, res = '0;
  logic [1:0]  opClass = '0;
  logic        wide = 1'b0, wrEn = 1'b0, ctlWe = 1'b0, ctlVal = 1'b0;
  logic [1:0]  ctlSel = 2'd3;
  logic carryFlag, parityFlag, auxFlag, zeroFlag, signFlag, ovfFlag;
  logic trapBit, intEnBit, dirBit;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  alu_flag_gen u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .res(res),
    .opClass(opClass), .wide(wide), .wrEn(wrEn), .ctlWe(ctlWe),
    .ctlSel(ctlSel), .ctlVal(ctlVal),
    .carryFlag(carryFlag), .parityFlag(parityFlag), .auxFlag(auxFlag),
    .zeroFlag(zeroFlag), .signFlag(signFlag), .ovfFlag(ovfFlag),
    .trapBit(trapBit), .intEnBit(intEnBit), .dirBit(dirBit)
  );

  // {class, wide, A, B, result, expected {cf,pf,af,zf,sf,of}}
  localparam int NVEC = 14;
  localparam logic [56:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 16'h000F, 16'h0001, 16'h0010, 6'b001000}, // R4 nibble carry
    {2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 6'b111100}, // R2 R5 byte wrap
    {2'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 6'b001011}, // R3 positive overflow
    {2'd0, 1'b1, 16'h8000, 16'h8000, 16'h0000, 6'b110101}, // R3 negative overflow
    {2'd0, 1'b1, 16'h00FF, 16'h0001, 16'h0100, 6'b011000}, // R5 R7 wide, low byte zero
    {2'd1, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 6'b111010}, // R2 borrow
    {2'd1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 6'b001001}, // R3 subtract overflow
    {2'd1, 1'b1, 16'h1234, 16'h1234, 16'h0000, 6'b010100}, // R5 equal operands
    {2'd1, 1'b1, 16'h0000, 16'h8000, 16'h8000, 6'b110011}, // R2 R3 wide borrow
    {2'd2, 1'b0, 16'h00F0, 16'h000F, 16'h00FF, 6'b010010}, // R8 logic narrow
    {2'd2, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 6'b010100}, // R8 logic zero
    {2'd2, 1'b1, 16'hFFFF, 16'h8003, 16'h8003, 6'b010010}, // R6 R8 logic sign
    {2'd0, 1'b0, 16'hAB05, 16'hCD03, 16'h7808, 6'b000000}, // R5 R6 upper bits ignored
    {2'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 6'b111100}  // R2 R4 wide wrap
  };

  function automatic logic [5:0] arithNow();
    return {carryFlag, parityFlag, auxFlag, zeroFlag, signFlag, ovfFlag};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] cls, input logic w, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] r, input logic we,
                       input logic cwe, input logic [1:0] sel, input logic val);
    @(negedge clk);
    opClass = cls; wide = w; opA = a; opB = b; res = r; wrEn = we;
    ctlWe = cwe; ctlSel = sel; ctlVal = val;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; ctlWe = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {arithNow(), trapBit, intEnBit, dirBit}, 9'b0);
    rstN = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R8, control bits stay 0 (R10)
    for (int i = 0; i < NVEC; i++) begin
      logic [56:0] v;
      v = VEC[i];
      drive(v[56:55], v[54], v[53:38], v[37:22], v[21:6], 1'b1, 1'b0, 2'd3, 1'b0);
      step();
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 R10 vector %0d", i),
            {arithNow(), trapBit, intEnBit, dirBit}, {v[5:0], 3'b000});
    end

    // R9 move leaves flags (last vector gave 111100)
    drive(2'd3, 1'b1, 16'h0001, 16'h0002, 16'h0041, 1'b1, 1'b0, 2'd3, 1'b0);
    step();
    check("R9 move", {3'b0, arithNow()}, {3'b0, 6'b111100});

    // R9 write enable low leaves flags
    drive(2'd0, 1'b0, 16'h0040, 16'h0040, 16'h0080, 1'b0, 1'b0, 2'd3, 1'b0);
    step();
    check("R9 idle", {3'b0, arithNow()}, {3'b0, 6'b111100});

    // R10 control bit commands
    drive(2'd3, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'd0, 1'b1);
    step();
    check("R10 set trap", {6'b0, trapBit, intEnBit, dirBit}, 9'b100);
    drive(2'd3, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'd2, 1'b1);
    step();
    drive(2'd3, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'd1, 1'b1);
    step();
    check("R10 set all", {arithNow(), trapBit, intEnBit, dirBit}, {6'b111100, 3'b111});
    drive(2'd3, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'd1, 1'b0);
    step();
    check("R10 clear intr", {6'b0, trapBit, intEnBit, dirBit}, 9'b101);
    drive(2'd3, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'd3, 1'b0);
    step();
    check("R10 select none", {6'b0, trapBit, intEnBit, dirBit}, 9'b101);
    drive(2'd3, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    step();
    check("R10 strobe low", {6'b0, trapBit, intEnBit, dirBit}, 9'b101);

    // R11 no change before the edge; arithmetic and control together
    drive(2'd0, 1'b0, 16'h000F, 16'h0001, 16'h0010, 1'b1, 1'b1, 2'd0, 1'b0);
    #1;
    check("R11 before edge", {arithNow(), trapBit, intEnBit, dirBit}, {6'b111100, 3'b101});
    step();
    check("R11 after edge", {arithNow(), trapBit, intEnBit, dirBit}, {6'b001000, 3'b001});

    // R1 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset again", {arithNow(), trapBit, intEnBit, dirBit}, 9'b0);
    rstN = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule